// File: doc/BRIEF.md
# Communication Watchdog Timer

This block guards a bus slave against a master that falls silent. A configuration flag switches it on. It then stays dormant until the first data-exchange or parameter-write call is received. From that call on it counts clock cycles. If no further data-exchange or parameter-write call arrives before the timeout expires, it raises a one-cycle request that the surrounding logic uses to reset the whole slave unconditionally.

The timeout is set by two parameters: the clock frequency and the timeout length in milliseconds. The default is 40 ms. Every other valid call on the bus is ignored, so only the two restart pulses hold the watchdog off. Decoding frames and distributing the reset are left to neighbouring blocks.

Top module: `comm_watchdog`

## Requirements
- R1: After reset, and after any later reset, `wdResetReq` is low and the watchdog is dormant. No request follows until a restart pulse is seen.
- R2: While `wdEnable` is low, the cycle count and the armed state are cleared on every clock and `wdResetReq` stays low. This includes a clock on which a timeout would otherwise fire. After re-enabling, the watchdog is dormant again.
- R3: Let LIMIT = TIMEOUT_MS * CLK_FREQ_HZ / 1000. The restart pulse is sampled at clock edge k, and no further restart follows. Then `wdResetReq` is high right after edge k+LIMIT+1, and never earlier.
- R4: Only `dexgSeen` and `wparSeen` restart the count. A restart pulse at edge k+LIMIT+1 wins over the timeout: no request is raised, and the full window starts again from that edge.
- R5: While enabled and never restarted, the watchdog raises no request, however long it waits.
- R6: `wdResetReq` is a single-cycle pulse. Afterwards the watchdog is dormant, so a continuing silence gives no second pulse.
- R7: `dexgSeen` and `wparSeen` high on the same edge act as one restart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wdEnable | input | 1 | Watchdog-active configuration flag |
| dexgSeen | input | 1 | One-cycle pulse: data-exchange call received |
| wparSeen | input | 1 | One-cycle pulse: parameter-write call received |
| wdResetReq | output | 1 | One-cycle unconditional reset request |

## Verification
Two things can fall on the same clock edge: the timeout firing, and either a restart pulse or the enable being dropped. The bench provokes each case by arming the watchdog and idling exactly LIMIT cycles. On the very next edge it then drives a restart pulse, or pulls `wdEnable` low. A correct design raises no request in either case. After a restart, the request must appear exactly LIMIT+1 edges later. After disabling, no request may appear at all.

// File: rtl/comm_watchdog_pkg.sv
package comm_watchdog_pkg;
  // strobes from control to the cycle counter
  typedef struct packed {
    logic clrCnt;
    logic incCnt;
  } wd_strobe_t;
endpackage

// File: rtl/comm_watchdog_count.sv
module comm_watchdog_count
  import comm_watchdog_pkg::*;
#(
  parameter int unsigned LIMIT = 100
) (
  input  logic       clk,
  input  logic       rstN,
  input  wd_strobe_t strobe,
  output logic       atLimit
);
  localparam int unsigned CW = (LIMIT < 1) ? 1 : $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cnt <= '0;
    else if (strobe.clrCnt) cnt <= '0;
    else if (strobe.incCnt) cnt <= cnt + 1'b1;
  end

  assign atLimit = (cnt == LIM);
endmodule

// File: rtl/comm_watchdog_ctrl.sv
module comm_watchdog_ctrl
  import comm_watchdog_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wdEnable,
  input  logic       kick,
  input  logic       atLimit,
  output wd_strobe_t strobe,
  output logic       resetReq
);
  logic armed;
  logic fire;

  // a restart always beats the timeout; a low enable beats both
  assign fire          = wdEnable && armed && !kick && atLimit;
  assign strobe.clrCnt = !wdEnable || kick || fire;
  assign strobe.incCnt = wdEnable && armed && !kick && !atLimit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armed    <= 1'b0;
      resetReq <= 1'b0;
    end else begin
      armed    <= wdEnable && (kick || (armed && !fire));
      resetReq <= fire;
    end
  end
endmodule

// File: rtl/comm_watchdog.sv
module comm_watchdog
  import comm_watchdog_pkg::*;
#(
  parameter int unsigned CLK_FREQ_HZ = 200_000_000,
  parameter int unsigned TIMEOUT_MS  = 40
) (
  input  logic clk,
  input  logic rstN,
  input  logic wdEnable,
  input  logic dexgSeen,
  input  logic wparSeen,
  output logic wdResetReq
);
  localparam longint unsigned LIMIT_L =
    longint'(TIMEOUT_MS) * longint'(CLK_FREQ_HZ) / 64'd1000;
  localparam int unsigned LIMIT = int'(LIMIT_L);

  wd_strobe_t strobe;
  logic       atLimit;
  logic       kick;

  assign kick = dexgSeen || wparSeen;

  comm_watchdog_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .wdEnable (wdEnable),
    .kick     (kick),
    .atLimit  (atLimit),
    .strobe   (strobe),
    .resetReq (wdResetReq)
  );

  comm_watchdog_count #(.LIMIT(LIMIT)) count_i (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .atLimit (atLimit)
  );
endmodule

// File: rtl/comm_watchdog_chk.sv
module comm_watchdog_chk #(
  parameter int unsigned LIMIT = 100
) (
  input logic clk,
  input logic rstN,
  input logic wdEnable,
  input logic dexgSeen,
  input logic wparSeen,
  input logic wdResetReq
);
  localparam int unsigned GW = $clog2(LIMIT + 3);
  localparam logic [GW-1:0] FIREGAP = GW'(LIMIT + 1);

  logic          seen;
  logic [GW-1:0] gap;
  logic          kick;

  assign kick = dexgSeen || wparSeen;

  // independent model of the silence since the last restart
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seen <= 1'b0;
      gap  <= '0;
    end else if (!wdEnable) begin
      seen <= 1'b0;
      gap  <= '0;
    end else if (kick) begin
      seen <= 1'b1;
      gap  <= '0;
    end else if (wdResetReq) begin
      seen <= 1'b0;
      gap  <= '0;
    end else if (seen && gap != FIREGAP) begin
      gap <= gap + 1'b1;
    end
  end

  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    wdResetReq |=> !wdResetReq);

  a_r2_disabled_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !wdEnable |=> !wdResetReq);

  a_r4_kick_blocks: assert property (@(posedge clk) disable iff (!rstN)
    (wdEnable && kick) |=> !wdResetReq);

  a_r3_no_early_fire: assert property (@(posedge clk) disable iff (!rstN)
    wdResetReq |-> (seen && gap == FIREGAP));

  a_r3_must_fire: assert property (@(posedge clk) disable iff (!rstN)
    (seen && gap == FIREGAP) |-> wdResetReq);
endmodule

bind comm_watchdog comm_watchdog_chk #(.LIMIT(LIMIT)) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .wdEnable   (wdEnable),
  .dexgSeen   (dexgSeen),
  .wparSeen   (wparSeen),
  .wdResetReq (wdResetReq)
);

// File: tb/comm_watchdog_tb_top.sv
`timescale 1ns/1ps
module comm_watchdog_tb_top;
  localparam int unsigned FREQ  = 2500;
  localparam int unsigned TMS   = 40;
  localparam int          LIMIT = TMS * FREQ / 1000;  // 100 cycles
  localparam int          NV    = 6;

  // vector table: kind (1 dexg, 2 wpar, 3 both), idle cycles, pulses, index
  localparam int    vKind  [NV] = '{1, 2, 1, 2, 3, 1};
  localparam int    vIdle  [NV] = '{50, LIMIT, LIMIT+1, LIMIT+1, LIMIT+1, 300};
  localparam int    vPulse [NV] = '{0, 0, 1, 1, 1, 1};
  localparam int    vIdx   [NV] = '{0, 0, LIMIT+1, LIMIT+1, LIMIT+1, LIMIT+1};
  localparam string vTag   [NV] = '{"R3", "R3", "R3", "R4", "R7", "R6"};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wdEnable = 1'b0;
  logic dexgSeen = 1'b0;
  logic wparSeen = 1'b0;
  logic wdResetReq;

  int tests = 0;
  int fails = 0;
  int widthErr = 0;
  logic prevReq = 1'b0;

  always #2.5 clk = ~clk;

  comm_watchdog #(.CLK_FREQ_HZ(FREQ), .TIMEOUT_MS(TMS)) dut_i (
    .clk(clk), .rstN(rstN), .wdEnable(wdEnable),
    .dexgSeen(dexgSeen), .wparSeen(wparSeen), .wdResetReq(wdResetReq)
  );

  task automatic check(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // called at a negedge; kick lines high across exactly one rising edge
  task automatic pulseKick(input int kind);
    dexgSeen = kind[0];
    wparSeen = kind[1];
    @(negedge clk);
    dexgSeen = 1'b0;
    wparSeen = 1'b0;
    prevReq  = wdResetReq;
  endtask

  task automatic idle(input int n, output int pulses, output int firstIdx);
    pulses = 0;
    firstIdx = 0;
    for (int i = 1; i <= n; i++) begin
      @(negedge clk);
      if (wdResetReq) begin
        if (prevReq) widthErr++;
        if (pulses == 0) firstIdx = i;
        pulses++;
      end
      prevReq = wdResetReq;
    end
  endtask

  int p, idx;

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset low", int'(wdResetReq), 0);
    rstN = 1'b1;
    wdEnable = 1'b1;
    idle(5, p, idx);
    check("R1 no request after reset", p, 0);

    // R5: enabled but never restarted
    idle(300, p, idx);
    check("R5 dormant pulses", p, 0);

    // table walk
    for (int v = 0; v < NV; v++) begin
      wdEnable = 1'b1;
      pulseKick(vKind[v]);
      idle(vIdle[v], p, idx);
      check({vTag[v], " pulses"}, p, vPulse[v]);
      check({vTag[v], " index"}, idx, vIdx[v]);
      wdEnable = 1'b0;
      idle(2, p, idx);
    end

    // R4: restart lands on the edge that would fire
    wdEnable = 1'b1;
    pulseKick(1);
    idle(LIMIT, p, idx);
    check("R4 before boundary", p, 0);
    pulseKick(2);
    check("R4 boundary kick suppresses", int'(wdResetReq), 0);
    idle(LIMIT + 1, p, idx);
    check("R4 restarted window index", idx, LIMIT + 1);
    idle(200, p, idx);
    check("R6 no second pulse", p, 0);

    // R2: disable mid-count then re-enable
    pulseKick(1);
    idle(60, p, idx);
    wdEnable = 1'b0;
    idle(1, p, idx);
    wdEnable = 1'b1;
    idle(300, p, idx);
    check("R2 re-enabled dormant", p, 0);

    // R2: disable on the firing edge
    pulseKick(2);
    idle(LIMIT, p, idx);
    wdEnable = 1'b0;
    idle(1, p, idx);
    check("R2 disable beats timeout", p, 0);
    wdEnable = 1'b1;
    idle(300, p, idx);
    check("R2 dormant after disable", p, 0);

    // R2: restart pulses ignored while disabled
    wdEnable = 1'b0;
    pulseKick(3);
    wdEnable = 1'b1;
    idle(300, p, idx);
    check("R2 kick while disabled ignored", p, 0);

    // R1: reset mid-count leaves it dormant
    pulseKick(1);
    idle(60, p, idx);
    rstN = 1'b0;
    idle(1, p, idx);
    rstN = 1'b1;
    idle(300, p, idx);
    check("R1 dormant after reset", p, 0);

    check("R6 pulse width", widthErr, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule